// File: doc/BRIEF.md
# Supervisory Watchdog and Reset Generator

This block drives the reset of a processor from two sources. The first is a supply-low flag that an external comparator has already brought into the clock domain. While that flag is high the reset output is held. Once the flag clears, the reset is stretched for one full pulse width before it is released. The second source is a watchdog timer that expects activity on a service input. Either edge of that input restarts the timer. If no edge arrives within the timeout, the block issues one reset pulse and then starts a fresh timeout interval. A service input that is never touched therefore produces a reset at a steady period of timeout plus pulse width.

The service input may carry pulses far shorter than one clock period. Each edge of it is captured by a toggle flop clocked by the input itself, and the toggle is then synchronised. The watchdog is switched off, and its timer held at zero, whenever the service input is reported as floating or the system runs in battery-backup mode. Two reset outputs are provided, active low and active high, and each is always the complement of the other. All intervals are parameters in clock ticks. The parameter check refuses a pulse width below a configurable floor.

Top module: `supv_reset_gen`

## Requirements
- R1: While `supply_low` is sampled high on a rising clock edge, `rst_n_o` is 0 after that edge, and it stays 0 for as long as the flag stays high.
- R2: After `supply_low` clears, `rst_n_o` stays 0 and rises on the PULSE_TICKS-th rising edge after the last edge at which the flag was sampled high. The watchdog interval then starts from zero.
- R3: `rst_o` is at every sample the logical inverse of `rst_n_o`.
- R4: With the watchdog enabled and `wd_in` static, `rst_n_o` is high for exactly TIMEOUT_TICKS cycles and then low for exactly PULSE_TICKS cycles, and this repeats.
- R5: A rising edge alone, or a falling edge alone, on `wd_in` restarts the timeout. Edges spaced less than TIMEOUT_TICKS cycles apart therefore prevent any watchdog reset.
- R6: A high pulse on `wd_in` whose rise and fall both fall between two clock edges counts as service.
- R7: While `wd_float` is 1 no watchdog reset occurs and the timer is held at zero. After release, `rst_n_o` stays high for exactly TIMEOUT_TICKS cycles, counted from the sample at which the flag is dropped.
- R8: `backup_mode` = 1 disables the watchdog in the same way as `wd_float`, with the same full interval after release.
- R9: Service edges during a reset pulse neither shorten the pulse, which is still PULSE_TICKS cycles, nor carry into the next interval, which is still TIMEOUT_TICKS cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| supply_low | input | 1 | Synchronous supply-below-threshold flag; also initialises the block |
| wd_in | input | 1 | Asynchronous watchdog service input |
| wd_float | input | 1 | Service input reported as floating; disables the watchdog |
| backup_mode | input | 1 | Battery-backup operation; disables the watchdog |
| rst_n_o | output | 1 | Reset to the processor, active low |
| rst_o | output | 1 | Reset to the processor, active high |

## Verification
The hardest case to reach from the ports is a service pulse that rises and falls entirely between two clock edges. A synchronised sample never sees such a pulse, so only the toggle capture can keep the timer alive. The bench drives pulses 1 ns wide in the gap after a falling clock edge, and it spaces them so that one missed pulse would let the timeout expire. The second hard case is a service edge that arrives inside a watchdog pulse. The bench times its edges from the first low sample of a pulse and measures the pulse, and the interval after it, to the exact cycle.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic {
        PH_HOLD  = 1'b0,
        PH_WATCH = 1'b1
    } supv_phase_e;

    function automatic int unsigned supv_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/supv_sync_chain.sv
module supv_sync_chain #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 1
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        stg_q[0] <= d_i;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/supv_svc_detect.sv
module supv_svc_detect #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic wd_in,
    output logic svc_o
);

    localparam int unsigned CAP_W = 3;

    // Toggle flops clocked by the service input: a change survives even
    // when the whole pulse lies between two clock edges.
    logic tog_rise_q;
    logic tog_fall_q;

    always_ff @(posedge wd_in) begin
        tog_rise_q <= ~tog_rise_q;
    end

    always_ff @(negedge wd_in) begin
        tog_fall_q <= ~tog_fall_q;
    end

    logic [CAP_W-1:0] sync_w;
    logic [CAP_W-1:0] prev_q;

    supv_sync_chain #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (CAP_W)
    ) u_sync (
        .clk (clk),
        .d_i ({tog_rise_q, tog_fall_q, wd_in}),
        .q_o (sync_w)
    );

    always_ff @(posedge clk) begin
        prev_q <= sync_w;
    end

    // Level change of the synchronised input ORed with either toggle change.
    assign svc_o = |(sync_w ^ prev_q);

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
    import supv_pkg::*;
#(
    parameter int unsigned TIMEOUT_TICKS   = 1600,
    parameter int unsigned PULSE_TICKS     = 200,
    parameter int unsigned MIN_PULSE_TICKS = 140,
    parameter int unsigned SYNC_STAGES     = 2
) (
    input  logic clk,
    input  logic supply_low,
    input  logic wd_in,
    input  logic wd_float,
    input  logic backup_mode,
    output logic rst_n_o,
    output logic rst_o
);

    localparam int unsigned MAX_TICKS = supv_max(TIMEOUT_TICKS, PULSE_TICKS);
    localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] TO_LAST = CNT_W'(TIMEOUT_TICKS - 1);
    localparam logic [CNT_W-1:0] PL_LAST = CNT_W'(PULSE_TICKS - 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    if (PULSE_TICKS < MIN_PULSE_TICKS) begin : g_pulse_floor
        $error("PULSE_TICKS is below MIN_PULSE_TICKS");
    end
    if (TIMEOUT_TICKS < 2 || SYNC_STAGES < 1) begin : g_param_range
        $error("TIMEOUT_TICKS must be at least 2 and SYNC_STAGES at least 1");
    end

    typedef struct packed {
        supv_phase_e      phase;
        logic [CNT_W-1:0] cnt;
        logic             rst_n;
        logic             rst;
    } supv_state_t;

    localparam supv_state_t ST_HOLD = '{
        phase: PH_HOLD,
        cnt:   '0,
        rst_n: 1'b0,
        rst:   1'b1
    };

    supv_state_t st_d;
    supv_state_t st_q;
    logic        svc_w;
    logic        wd_off_w;

    supv_svc_detect #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_svc (
        .clk   (clk),
        .wd_in (wd_in),
        .svc_o (svc_w)
    );

    assign wd_off_w = wd_float | backup_mode;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_HOLD: begin
                // Service edges are ignored here: the pulse always runs out.
                if (st_q.cnt == PL_LAST) begin
                    st_d.phase = PH_WATCH;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_ONE;
                end
            end
            PH_WATCH: begin
                if (wd_off_w || svc_w) begin
                    st_d.cnt = '0;
                end else if (st_q.cnt == TO_LAST) begin
                    st_d.phase = PH_HOLD;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_ONE;
                end
            end
            default: st_d = ST_HOLD;
        endcase
        st_d.rst_n = (st_d.phase == PH_WATCH);
        st_d.rst   = (st_d.phase == PH_HOLD);
    end

    // The supply flag is the only initialiser: it is high while power ramps.
    always_ff @(posedge clk) begin
        if (supply_low) begin
            st_q <= ST_HOLD;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_n_o = st_q.rst_n;
    assign rst_o   = st_q.rst;

endmodule

// File: rtl/supv_reset_gen_chk.sv
module supv_reset_gen_chk #(
    parameter int unsigned PULSE_TICKS = 200
) (
    input logic clk,
    input logic supply_low,
    input logic wd_float,
    input logic backup_mode,
    input logic rst_n_o,
    input logic rst_o
);

    localparam int unsigned RUN_W = $clog2(PULSE_TICKS + 2);
    localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

    logic             armed_q;
    logic [RUN_W-1:0] low_run_q;

    always_ff @(posedge clk) begin
        if (supply_low) begin
            armed_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (supply_low || rst_n_o) begin
            low_run_q <= '0;
        end else if (low_run_q != RUN_MAX) begin
            low_run_q <= low_run_q + 1'b1;
        end
    end

    // R1
    supply_hold_chk: assert property (@(posedge clk) disable iff (!armed_q)
        supply_low |=> !rst_n_o);

    // R3
    polarity_pair_chk: assert property (@(posedge clk) disable iff (!armed_q)
        rst_o == !rst_n_o);

    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (!armed_q)
        $rose(rst_n_o) |-> (low_run_q == RUN_W'(PULSE_TICKS)));

    // R7
    wd_disabled_chk: assert property (@(posedge clk) disable iff (!armed_q)
        (!supply_low && (wd_float || backup_mode) && rst_n_o) |=> rst_n_o);

endmodule

bind supv_reset_gen supv_reset_gen_chk #(
    .PULSE_TICKS (PULSE_TICKS)
) u_chk (
    .clk         (clk),
    .supply_low  (supply_low),
    .wd_float    (wd_float),
    .backup_mode (backup_mode),
    .rst_n_o     (rst_n_o),
    .rst_o       (rst_o)
);

// File: tb/sim_supv_reset_gen.sv
`timescale 1ns/1ps
module sim_supv_reset_gen;

    localparam int unsigned T_TICKS = 40;
    localparam int unsigned P_TICKS = 16;

    logic clk = 1'b0;
    logic supply_low = 1'b1;
    logic wd_in = 1'b0;
    logic wd_float = 1'b0;
    logic backup_mode = 1'b0;
    logic rst_n_o;
    logic rst_o;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    supv_reset_gen #(
        .TIMEOUT_TICKS   (T_TICKS),
        .PULSE_TICKS     (P_TICKS),
        .MIN_PULSE_TICKS (12),
        .SYNC_STAGES     (2)
    ) u0 (
        .clk         (clk),
        .supply_low  (supply_low),
        .wd_in       (wd_in),
        .wd_float    (wd_float),
        .backup_mode (backup_mode),
        .rst_n_o     (rst_n_o),
        .rst_o       (rst_o)
    );

    // svc: 0 none, 1 toggle wd_in, 2 short pulse inside one clock period
    typedef struct packed {
        logic       sup;
        logic       flt;
        logic       bkp;
        logic [1:0] svc;
        logic [7:0] cyc;
        logic       exp_n;
        logic [3:0] req;
    } row_t;

    localparam int NROW = 14;
    localparam row_t ROWS [NROW] = '{
        '{1'b1, 1'b0, 1'b0, 2'd0, 8'd20,  1'b0, 4'd1}, // R1 supply held low
        '{1'b0, 1'b0, 1'b0, 2'd0, 8'd14,  1'b0, 4'd2}, // R2 stretch after release
        '{1'b0, 1'b0, 1'b0, 2'd0, 8'd1,   1'b0, 4'd2}, // R2 last low sample
        '{1'b0, 1'b1, 1'b0, 2'd0, 8'd120, 1'b1, 4'd7}, // R7 floating input
        '{1'b0, 1'b0, 1'b1, 2'd0, 8'd120, 1'b1, 4'd8}, // R8 backup mode
        '{1'b0, 1'b0, 1'b0, 2'd1, 8'd30,  1'b1, 4'd5}, // R5 rising edge
        '{1'b0, 1'b0, 1'b0, 2'd1, 8'd30,  1'b1, 4'd5}, // R5 falling edge
        '{1'b0, 1'b0, 1'b0, 2'd1, 8'd30,  1'b1, 4'd5}, // R5 rising edge
        '{1'b0, 1'b0, 1'b0, 2'd1, 8'd30,  1'b1, 4'd5}, // R5 falling edge
        '{1'b0, 1'b0, 1'b0, 2'd2, 8'd30,  1'b1, 4'd6}, // R6 short pulse
        '{1'b0, 1'b0, 1'b0, 2'd2, 8'd30,  1'b1, 4'd6}, // R6 short pulse
        '{1'b0, 1'b0, 1'b0, 2'd2, 8'd30,  1'b1, 4'd6}, // R6 short pulse
        '{1'b1, 1'b0, 1'b0, 2'd0, 8'd60,  1'b0, 4'd1}, // R1 brown-out mid interval
        '{1'b0, 1'b0, 1'b0, 2'd0, 8'd14,  1'b0, 4'd2}  // R2 stretch again
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (rst_n_o === lvl && n < 500) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic short_pulse();
        #1 wd_in = 1'b1;
        #1 wd_in = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin : watchdog_timer
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin : stim
        int n;
        bit row_ok;
        int bad_val;

        repeat (5) @(negedge clk);
        // R1 / R3 reset state
        check(rst_n_o === 1'b0, "R1", int'(rst_n_o), 0);
        check(rst_o === 1'b1, "R3", int'(rst_o), 1);

        for (int r = 0; r < NROW; r++) begin
            supply_low  = ROWS[r].sup;
            wd_float    = ROWS[r].flt;
            backup_mode = ROWS[r].bkp;
            if (ROWS[r].svc == 2'd1) wd_in = ~wd_in;
            else if (ROWS[r].svc == 2'd2) short_pulse();
            row_ok = 1'b1;
            bad_val = int'(ROWS[r].exp_n);
            for (int k = 0; k < int'(ROWS[r].cyc); k++) begin
                @(negedge clk);
                if (rst_n_o !== ROWS[r].exp_n || rst_o !== ~ROWS[r].exp_n) begin
                    row_ok = 1'b0;
                    bad_val = int'(rst_n_o);
                end
            end
            check(row_ok, $sformatf("R%0d row %0d", ROWS[r].req, r), bad_val, int'(ROWS[r].exp_n));
        end

        // R4 free-running watchdog period with a static input
        while (rst_n_o !== 1'b1) @(negedge clk);
        run_len(1'b1, n);
        check(n == int'(T_TICKS), "R4 first interval", n, T_TICKS);
        run_len(1'b0, n);
        check(n == int'(P_TICKS), "R4 pulse width", n, P_TICKS);
        run_len(1'b1, n);
        check(n == int'(T_TICKS), "R4 repeat interval", n, T_TICKS);
        check(rst_o === 1'b1, "R3 during pulse", int'(rst_o), 1);

        // R9 service edges inside a pulse are ignored
        n = 0;
        while (rst_n_o === 1'b0 && n < 500) begin
            if (n == 0 || n == 3) wd_in = ~wd_in;
            n++;
            @(negedge clk);
        end
        check(n == int'(P_TICKS), "R9 pulse not shortened", n, P_TICKS);
        run_len(1'b1, n);
        check(n == int'(T_TICKS), "R9 next interval full", n, T_TICKS);

        // R7 timer held cleared while floating
        run_len(1'b0, n);
        wd_float = 1'b1;
        repeat (100) @(negedge clk);
        check(rst_n_o === 1'b1, "R7 no reset while floating", int'(rst_n_o), 1);
        wd_float = 1'b0;
        run_len(1'b1, n);
        check(n == int'(T_TICKS), "R7 full interval after release", n, T_TICKS);

        // R8 timer held cleared in backup mode
        run_len(1'b0, n);
        backup_mode = 1'b1;
        repeat (100) @(negedge clk);
        backup_mode = 1'b0;
        run_len(1'b1, n);
        check(n == int'(T_TICKS), "R8 full interval after backup", n, T_TICKS);

        // R2 supply dip inside a watchdog pulse restarts the stretch
        repeat (3) @(negedge clk);
        supply_low = 1'b1;
        repeat (5) @(negedge clk);
        check(rst_n_o === 1'b0, "R1 dip in pulse", int'(rst_n_o), 0);
        supply_low = 1'b0;
        run_len(1'b0, n);
        check(n == int'(P_TICKS), "R2 stretch after dip", n, P_TICKS);
        check(rst_o === 1'b0, "R3 after release", int'(rst_o), 0);

        finish_run();
    end

endmodule